// File: doc/BRIEF.md
# Parallel Host to Serial Byte Bridge Controller

This block sits on the peripheral side of an 8-bit parallel host port and feeds a serial byte engine. The host moves one byte per strobe: with the direction line high it reads, with it low it writes. A separate select line lets a write load a register pointer instead of sending data. The pointer chooses between the data path (receive and transmit buffers), a port number, a modem pin register, a baud setting, an event enable register and an event status register.

Two flow lines tell the host whether the receive buffer holds bytes and whether the transmit buffer has room. The same lines double as the per-byte acknowledge of the handshake. Interrupt events come from the buffer fill levels. Each one fires once, and it can fire again only after the fill level has moved back past a re-arm point. The serial engine is modelled as a byte-wide valid/ready pair on each side.

Top module: `uart_host_bridge`

## Requirements
- R1: A write with `host_sel` high loads bits [2:0] of the bus into the register pointer and puts nothing in the transmit buffer.
- R2: Pointer values: 0 data buffers, 1 port number, 2 modem pins (reads return `modem_in`, writes set `modem_out`), 3 baud setting, 4 event enable, 5 event status. Reads of 1, 3 and 4 return the value last written.
- R3: A data read or write through a non-zero pointer returns the pointer to 0 afterwards.
- R4: A pointer left non-zero for TIMEOUT_CYC cycles returns to 0 by itself.
- R5: While idle, `data_wait` is high exactly when the receive buffer is non-empty. A read strobe puts the oldest byte on the bus with `host_oe` high and drops `data_wait`. Releasing the direction line floats the bus and restores `data_wait`.
- R6: A data read from an empty receive buffer returns 0x00 and removes nothing.
- R7: A write strobe stores the byte in the transmit buffer, and the bytes leave on `tx_byte` in write order. `clr_send` is low while the strobe is held. After release it is high exactly when the transmit buffer has room.
- R8: A data write to a full transmit buffer is dropped. The buffered bytes are unchanged.
- R9: Status bit 0 sets on every byte accepted from the serial side.
- R10: Status bit 1 sets once when the receive buffer becomes non-empty. It fires again only after the buffer has been empty.
- R11: Status bit 2 sets once when receive occupancy reaches 3/4 of DEPTH. It fires again only after occupancy has fallen to DEPTH/4 or below.
- R12: Status bit 3 sets once when the transmit buffer drains to empty after holding data.
- R13: `irq` is the OR of status bits ANDed with their enable bits. Writing ones to register 5 clears those status bits.
- R14: A strobe held low for many cycles moves exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_din | input | 8 | Parallel bus, host to bridge |
| host_dout | output | 8 | Parallel bus, bridge to host |
| host_oe | output | 1 | Bridge drives the bus |
| host_rd | input | 1 | Direction: 1 read, 0 write |
| host_stb_n | input | 1 | Active-low byte strobe |
| host_sel | input | 1 | Write loads the register pointer |
| data_wait | output | 1 | Receive data available / read acknowledge |
| clr_send | output | 1 | Transmit room / write acknowledge |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Serial engine offers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Byte available for the serial engine |
| tx_ready | input | 1 | Serial engine takes the byte |
| tx_byte | output | 8 | Byte to transmit |
| modem_in | input | 8 | Modem pin levels |
| modem_out | output | 8 | Modem pin drive |
| port_num | output | 8 | Selected port number |
| baud_sel | output | 8 | Baud setting |

## Verification
A pointer stuck at a non-zero value shows at once: the next data write lands in a configuration register, so a byte is missing from the transmit stream. A wrong buffer occupancy shows on `data_wait` or `clr_send` within a few cycles of the handshake ending. It also shows as a byte that is missing, extra or out of order, and the scoreboard compares each byte as soon as it appears. A broken arming flag in the event logic shows up the next time the status register is read after the threshold crossing. It appears either as a repeat event or as a missing one.

// File: rtl/uart_bridge_pkg.sv
package uart_bridge_pkg;
   typedef enum logic [2:0] {
      SEL_DATA  = 3'd0,
      SEL_PORT  = 3'd1,
      SEL_MODEM = 3'd2,
      SEL_BAUD  = 3'd3,
      SEL_IEN   = 3'd4,
      SEL_ISTAT = 3'd5
   } reg_sel_e;

   localparam int NUM_EVT   = 4;
   localparam int EV_RXBYTE = 0;
   localparam int EV_NEMPTY = 1;
   localparam int EV_NFULL  = 2;
   localparam int EV_TXDONE = 3;
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
   parameter int W       = 3,
   parameter int STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bridge_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
      end else begin
         chain_q[0] <= d;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bridge_fifo.sv
module bridge_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);
   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;
   logic          push_ok, pop_ok;

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("bridge_fifo DEPTH must be a power of two of at least 4");
      end
   endgenerate

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CW'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = mem_q[rd_q];
   assign count   = cnt_q;

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wr_q] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wr_q <= wr_q + 1'b1;
         if (pop_ok)  rd_q <= rd_q + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R8: a push into a full buffer leaves the occupancy unchanged
   a_r8_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (count == $past(count)));
   // R6: popping an empty buffer does nothing
   a_r6_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);
endmodule

// File: rtl/bridge_irq.sv
module bridge_irq
   import uart_bridge_pkg::*;
#(
   parameter int DEPTH = 256,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int HI   = (DEPTH * 3) / 4,
   localparam int LO   = DEPTH / 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_accept,
   input  logic [CW-1:0]      rx_count,
   input  logic [CW-1:0]      tx_count,
   input  logic               clr_we,
   input  logic [NUM_EVT-1:0] clr_mask,
   output logic [NUM_EVT-1:0] status
);
   logic [NUM_EVT-1:0] stat_q, set_vec;
   logic arm_ne_q, arm_nf_q, arm_te_q;
   logic fire_ne, fire_nf, fire_te;

   assign fire_ne = arm_ne_q && (rx_count != '0);
   assign fire_nf = arm_nf_q && (rx_count >= CW'(HI));
   assign fire_te = arm_te_q && (tx_count == '0);

   always_comb begin
      set_vec            = '0;
      set_vec[EV_RXBYTE] = rx_accept;
      set_vec[EV_NEMPTY] = fire_ne;
      set_vec[EV_NFULL]  = fire_nf;
      set_vec[EV_TXDONE] = fire_te;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q   <= '0;
         arm_ne_q <= 1'b1;
         arm_nf_q <= 1'b1;
         arm_te_q <= 1'b0;
      end else begin
         stat_q <= (stat_q & ~(clr_we ? clr_mask : '0)) | set_vec;
         if (rx_count == '0)         arm_ne_q <= 1'b1;
         else if (fire_ne)           arm_ne_q <= 1'b0;
         if (rx_count <= CW'(LO))    arm_nf_q <= 1'b1;
         else if (fire_nf)           arm_nf_q <= 1'b0;
         if (tx_count != '0)         arm_te_q <= 1'b1;
         else if (fire_te)           arm_te_q <= 1'b0;
      end
   end

   assign status = stat_q;

   // R10: not-empty event cannot repeat while the buffer stays occupied
   a_r10_nempty_once: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm_ne_q && rx_count != '0) |=> !arm_ne_q);
   // R11: nearly-full event disarmed above the low mark stays disarmed
   a_r11_nfull_hyst: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm_nf_q && rx_count > CW'(LO)) |=> !arm_nf_q);
endmodule

// File: rtl/uart_host_bridge.sv
module uart_host_bridge
   import uart_bridge_pkg::*;
#(
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_CYC = 250_000_000,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int TW = $clog2(TIMEOUT_CYC + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] host_din,
   output logic [7:0] host_dout,
   output logic       host_oe,
   input  logic       host_rd,
   input  logic       host_stb_n,
   input  logic       host_sel,
   output logic       data_wait,
   output logic       clr_send,
   output logic       irq,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   output logic       tx_valid,
   input  logic       tx_ready,
   output logic [7:0] tx_byte,
   input  logic [7:0] modem_in,
   output logic [7:0] modem_out,
   output logic [7:0] port_num,
   output logic [7:0] baud_sel
);
   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   // host control synchronisation
   logic [2:0] ctl_s;
   logic stb_s, rd_s, sel_s, stb_prev_q, stb_fall;
   bridge_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({host_stb_n, host_rd, host_sel}), .q(ctl_s));
   assign {stb_s, rd_s, sel_s} = ctl_s;
   assign stb_fall = stb_prev_q && !stb_s;

   // buffers
   logic [7:0]    rx_head, tx_head;
   logic          rx_empty, rx_full, tx_empty, tx_full;
   logic [CW-1:0] rx_count, tx_count;
   logic          rx_pop, tx_push, tx_pop;

   bridge_fifo #(.W(8), .DEPTH(DEPTH)) u_rx_buf (
      .clk(clk), .rst_n(rst_n), .push(rx_valid), .push_data(rx_byte),
      .pop(rx_pop), .head(rx_head), .empty(rx_empty), .full(rx_full),
      .count(rx_count));

   bridge_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_buf (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .push_data(host_din),
      .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full),
      .count(tx_count));

   assign tx_valid = !tx_empty;
   assign tx_byte  = tx_head;
   assign tx_pop   = tx_valid && tx_ready;

   // handshake and register access
   logic       rd_start, wr_start, ptr_load, data_wr;
   logic [2:0] ptr_q;
   logic       rd_busy_q, wr_ack_q;
   logic [7:0] rd_q, rd_mux;
   logic [7:0] port_q, modem_q, baud_q;
   logic [NUM_EVT-1:0] ien_q, istat;
   logic [TW-1:0] idle_q;
   logic       clr_we;

   assign rd_start = stb_fall && rd_s;
   assign wr_start = stb_fall && !rd_s;
   assign ptr_load = wr_start && sel_s;
   assign data_wr  = wr_start && !sel_s;
   assign rx_pop   = rd_start && (ptr_q == SEL_DATA) && !rx_empty;
   assign tx_push  = data_wr && (ptr_q == SEL_DATA);
   assign clr_we   = data_wr && (ptr_q == SEL_ISTAT);

   always_comb begin
      case (ptr_q)
         SEL_DATA:  rd_mux = rx_empty ? 8'h00 : rx_head;
         SEL_PORT:  rd_mux = port_q;
         SEL_MODEM: rd_mux = modem_in;
         SEL_BAUD:  rd_mux = baud_q;
         SEL_IEN:   rd_mux = {{(8-NUM_EVT){1'b0}}, ien_q};
         SEL_ISTAT: rd_mux = {{(8-NUM_EVT){1'b0}}, istat};
         default:   rd_mux = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_prev_q <= 1'b1;
         rd_busy_q  <= 1'b0;
         wr_ack_q   <= 1'b0;
         rd_q       <= 8'h00;
      end else begin
         stb_prev_q <= stb_s;
         if (rd_start) begin
            rd_busy_q <= 1'b1;
            rd_q      <= rd_mux;
         end else if (!rd_s) begin
            rd_busy_q <= 1'b0;
         end
         if (wr_start)   wr_ack_q <= 1'b1;
         else if (stb_s) wr_ack_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= SEL_DATA;
         idle_q <= '0;
      end else if (ptr_load) begin
         ptr_q  <= host_din[2:0];
         idle_q <= '0;
      end else if ((rd_start || data_wr) && ptr_q != SEL_DATA) begin
         ptr_q  <= SEL_DATA;
         idle_q <= '0;
      end else if (ptr_q != SEL_DATA) begin
         if (idle_q == TW'(TIMEOUT_CYC - 1)) begin
            ptr_q  <= SEL_DATA;
            idle_q <= '0;
         end else begin
            idle_q <= idle_q + 1'b1;
         end
      end else begin
         idle_q <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_q  <= 8'h00;
         modem_q <= 8'h00;
         baud_q  <= 8'h00;
         ien_q   <= '0;
      end else if (data_wr) begin
         case (ptr_q)
            SEL_PORT:  port_q  <= host_din;
            SEL_MODEM: modem_q <= host_din;
            SEL_BAUD:  baud_q  <= host_din;
            SEL_IEN:   ien_q   <= host_din[NUM_EVT-1:0];
            default:   ;
         endcase
      end
   end

   bridge_irq #(.DEPTH(DEPTH)) u_irq (
      .clk(clk), .rst_n(rst_n), .rx_accept(rx_valid && !rx_full),
      .rx_count(rx_count), .tx_count(tx_count), .clr_we(clr_we),
      .clr_mask(host_din[NUM_EVT-1:0]), .status(istat));

   assign irq       = |(istat & ien_q);
   assign host_oe   = rd_busy_q;
   assign host_dout = rd_busy_q ? rd_q : 8'h00;
   assign data_wait = !rd_busy_q && !rx_empty;
   assign clr_send  = !wr_ack_q && !tx_full;
   assign modem_out = modem_q;
   assign port_num  = port_q;
   assign baud_sel  = baud_q;

   // R5: the bridge never drives the bus while signalling data waiting
   a_r5_bus_quiets_wait: assert property (@(posedge clk) disable iff (!rst_n)
      host_oe |-> !data_wait);
   // R7: write acknowledge holds clear-to-send low
   a_r7_ack_blocks_send: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack_q |-> !clr_send);
   // R3: a data access through a non-zero pointer returns it to zero
   a_r3_ptr_auto_return: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_start || data_wr) && ptr_q != SEL_DATA) |=> (ptr_q == SEL_DATA));
   // R14: one strobe removes at most one received byte
   a_r14_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |=> !rx_pop);
endmodule

// File: tb/uart_host_bridge_bench.sv
module uart_host_bridge_bench;
   localparam int DEPTH = 16;
   localparam int TMO   = 300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] host_din = 8'h00;
   logic [7:0] host_dout;
   logic host_oe, host_rd = 1'b0, host_stb_n = 1'b1, host_sel = 1'b0;
   logic data_wait, clr_send, irq;
   logic rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic tx_valid, tx_ready = 1'b1;
   logic [7:0] tx_byte;
   logic [7:0] modem_in = 8'h5A;
   logic [7:0] modem_out, port_num, baud_sel;

   int checks = 0;
   int errors = 0;
   int tx_model = 0;
   logic [7:0] tx_exp[$];
   logic [7:0] rx_exp[$];

   always #2 clk = ~clk;

   uart_host_bridge #(.DEPTH(DEPTH), .TIMEOUT_CYC(TMO)) u_uart_host_bridge (
      .clk(clk), .rst_n(rst_n), .host_din(host_din), .host_dout(host_dout),
      .host_oe(host_oe), .host_rd(host_rd), .host_stb_n(host_stb_n),
      .host_sel(host_sel), .data_wait(data_wait), .clr_send(clr_send),
      .irq(irq), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .tx_byte(tx_byte), .modem_in(modem_in),
      .modem_out(modem_out), .port_num(port_num), .baud_sel(baud_sel));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // scoreboard monitor for the transmit stream (R7, R8)
   always @(negedge clk) begin
      if (rst_n && tx_valid && tx_ready) begin
         if (tx_exp.size() == 0) check(0, "R7 unexpected tx byte", tx_byte, 0);
         else begin
            logic [7:0] e;
            e = tx_exp.pop_front();
            check(tx_byte == e, "R7 tx order", tx_byte, e);
         end
         tx_model--;
      end
   end

   task automatic host_write(input bit sel, input logic [7:0] d);
      @(negedge clk);
      host_sel = sel; host_rd = 1'b0; host_din = d; host_stb_n = 1'b0;
      idle(6);
      host_stb_n = 1'b1;
      idle(6);
      host_sel = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] d);
      if (tx_model < DEPTH) begin
         tx_exp.push_back(d);
         tx_model++;
      end
      host_write(1'b0, d);
   endtask

   task automatic host_read(output logic [7:0] d, input int hold);
      @(negedge clk);
      host_rd = 1'b1; host_stb_n = 1'b0;
      idle(hold);
      d = host_dout;
      check(host_oe == 1'b1, "R5 bus driven during read", host_oe, 1);
      check(data_wait == 1'b0, "R5 data_wait low during read", data_wait, 0);
      host_stb_n = 1'b1; host_rd = 1'b0;
      idle(6);
      check(host_oe == 1'b0, "R5 bus floated after read", host_oe, 0);
   endtask

   task automatic read_rx(input string req);
      logic [7:0] d, e;
      e = (rx_exp.size() == 0) ? 8'h00 : rx_exp.pop_front();
      host_read(d, 6);
      check(d == e, req, d, e);
   endtask

   task automatic reg_write(input logic [2:0] idx, input logic [7:0] v);
      host_write(1'b1, {5'd0, idx});
      host_write(1'b0, v);
   endtask

   task automatic reg_read(input logic [2:0] idx, output logic [7:0] v);
      host_write(1'b1, {5'd0, idx});
      host_read(v, 6);
   endtask

   task automatic push_rx(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0;
      rx_exp.push_back(b);
      idle(2);
   endtask

   task automatic expect_stat(input logic [7:0] exp, input string req);
      logic [7:0] v;
      reg_read(3'd5, v);
      check(v == exp, req, v, exp);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      check(0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      idle(4);
      rst_n = 1'b1;
      idle(2);
      // reset state
      check(data_wait == 1'b0, "R5 reset data_wait", data_wait, 0);
      check(clr_send == 1'b1, "R7 reset clr_send", clr_send, 1);
      check(irq == 1'b0, "R13 reset irq", irq, 0);
      check(host_oe == 1'b0, "R5 reset bus float", host_oe, 0);

      // R2 register map, R1 pointer load, R3 auto return
      reg_write(3'd1, 8'h03);
      check(port_num == 8'h03, "R2 port number", port_num, 8'h03);
      reg_write(3'd3, 8'h05);
      check(baud_sel == 8'h05, "R2 baud setting", baud_sel, 8'h05);
      reg_write(3'd2, 8'hC3);
      check(modem_out == 8'hC3, "R2 modem out", modem_out, 8'hC3);
      reg_read(3'd2, v);
      check(v == 8'h5A, "R2 modem pin read", v, 8'h5A);
      reg_read(3'd3, v);
      check(v == 8'h05, "R2 baud readback", v, 8'h05);
      check(tx_exp.size() == 0 && tx_valid == 1'b0, "R1 pointer write sends nothing", tx_valid, 0);
      send_byte(8'h11);   // R3: pointer back at data after the accesses above
      idle(4);
      check(port_num == 8'h03 && baud_sel == 8'h05, "R3 data write left config alone", port_num, 8'h03);

      // R4 timeout return
      host_write(1'b1, 8'h01);
      idle(TMO + 20);
      send_byte(8'h22);
      idle(4);
      check(port_num == 8'h03, "R4 pointer timed out to data", port_num, 8'h03);
      check(tx_exp.size() == 0, "R4 byte reached tx", tx_exp.size(), 0);

      // R6 empty read, R5 read handshake
      read_rx("R6 empty read returns zero");
      check(data_wait == 1'b0, "R6 still empty", data_wait, 0);
      push_rx(8'hA1);
      push_rx(8'hB2);
      check(data_wait == 1'b1, "R5 data_wait when non-empty", data_wait, 1);
      // R14 long strobe moves one byte
      begin
         logic [7:0] d;
         host_read(d, 40);
         check(d == 8'hA1, "R14 long strobe byte", d, 8'hA1);
         void'(rx_exp.pop_front());
      end
      check(data_wait == 1'b1, "R14 one byte left", data_wait, 1);
      read_rx("R5 second byte");
      check(data_wait == 1'b0, "R5 data_wait after drain", data_wait, 0);

      // R7 ack and R8 full drop
      @(negedge clk);
      host_rd = 1'b0; host_din = 8'h33; host_stb_n = 1'b0;
      tx_exp.push_back(8'h33); tx_model++;
      idle(6);
      check(clr_send == 1'b0, "R7 ack while strobe held", clr_send, 0);
      host_stb_n = 1'b1;
      idle(6);
      check(clr_send == 1'b1, "R7 clr_send restored", clr_send, 1);
      tx_ready = 1'b0;
      for (int i = 0; i < DEPTH + 2; i++) send_byte(8'h40 + 8'(i));
      check(clr_send == 1'b0, "R8 clr_send low when full", clr_send, 0);
      tx_ready = 1'b1;
      idle(DEPTH + 10);
      check(tx_exp.size() == 0, "R8 only buffered bytes sent", tx_exp.size(), 0);
      check(clr_send == 1'b1, "R7 room after drain", clr_send, 1);

      // events
      reg_write(3'd5, 8'hFF);
      reg_write(3'd4, 8'h0F);
      check(irq == 1'b0, "R13 irq clear", irq, 0);
      push_rx(8'h01);
      expect_stat(8'h03, "R9 R10 first byte events");
      check(irq == 1'b1, "R13 irq raised", irq, 1);
      reg_write(3'd5, 8'h03);
      check(irq == 1'b0, "R13 w1c clears", irq, 0);
      push_rx(8'h02);
      expect_stat(8'h01, "R10 no repeat while occupied");
      reg_write(3'd5, 8'hFF);
      for (int i = 0; i < 10; i++) push_rx(8'h10 + 8'(i));
      expect_stat(8'h05, "R11 nearly full at 3/4");
      reg_write(3'd5, 8'hFF);
      reg_write(3'd4, 8'h00);
      push_rx(8'h20);
      idle(2);
      check(irq == 1'b0, "R13 masked event no irq", irq, 0);
      expect_stat(8'h01, "R11 no repeat above low mark");
      reg_write(3'd5, 8'hFF);
      reg_write(3'd4, 8'h0F);
      for (int i = 0; i < 9; i++) read_rx("R5 drain to low mark");
      for (int i = 0; i < 8; i++) push_rx(8'h30 + 8'(i));
      expect_stat(8'h05, "R11 rearmed after low mark");
      reg_write(3'd5, 8'hFF);
      while (rx_exp.size() > 0) read_rx("R5 drain all");
      push_rx(8'h77);
      expect_stat(8'h03, "R10 rearmed after empty");
      read_rx("R5 final byte");
      reg_write(3'd5, 8'hFF);
      send_byte(8'h91);
      send_byte(8'h92);
      idle(10);
      expect_stat(8'h08, "R12 tx drained event");
      check(irq == 1'b1, "R12 irq from tx empty", irq, 1);
      reg_write(3'd5, 8'h08);
      idle(10);
      expect_stat(8'h00, "R12 no repeat while empty");

      idle(10);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule